// File: doc/BRIEF.md
# Oversampled Bit Clock and Data Recovery Loop

This block takes the single-bit output of a demodulator's slicer. It samples that bit on a clock running at a fixed multiple of the nominal bit rate, which is 32 by default. From those samples it rebuilds a local bit clock and a retimed data bit. A phase counter acts as a small numerically controlled oscillator and wraps once per nominal bit. Each accepted transition of the input is timed against that counter. A transition that arrives away from the bit boundary moves the counter phase by one sample, either earlier or later, and at most once per bit. When the stream carries no transitions, the counter free-runs and keeps its last phase.

The recovered data is the filtered input level taken at mid-bit, and a one-cycle strobe marks it. A receiver uses the strobe to shift bits into its framer. A packet should open with an alternating preamble. That pattern gives the loop a transition in every bit, so it can pull in phase and track a rate offset of about three percent.

Top module: `cdr_dpll`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bclk`, `dout` and `dvalid` are all 0. The phase count is 0.
- R2: With `en` high and no correction, the phase count rises by one per clock and wraps from 31 to 0. `bclk` is 1 exactly while the count is in 16..31.
- R3: The held input level changes only after two consecutive samples agree and differ from it. A level lasting a single sample is ignored and never reaches `dout`.
- R4: An accepted transition seen at count 2..15 lengthens the bit: the count holds for one clock. One seen at count 16..30 shortens the bit: the count steps by two. One seen at count 31, 0 or 1 causes no change.
- R5: At most one correction is applied between two successive arrivals of the count at 0. Later transitions in the same bit are ignored.
- R6: During a run of identical input bits no correction occurs, and strobes are spaced exactly 32 clocks apart.
- R7: The clock after a cycle with `en` high and count 16, `dvalid` is 1 for one cycle and `dout` holds the level accepted at that count. `dout` keeps its value at all other times.
- R8: While `en` is low, the count is frozen (so `bclk` does not change), no correction is made and `dvalid` stays 0.
- R9: An alternating stream whose bit period is 3% shorter or 3% longer than nominal is recovered without slips once 64 bits have passed. Every recovered bit then differs from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 32 times the nominal bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Loop enable; low freezes the phase count |
| din | input | 1 | Raw slicer bit |
| bclk | output | 1 | Recovered bit clock, rising at mid-bit |
| dout | output | 1 | Retimed data bit |
| dvalid | output | 1 | One-cycle strobe per recovered bit |

## Verification
On every cycle, the embedded properties check the following:
- the count moves by 0, 1 or 2 per enabled clock, and by exactly 1 when no transition is accepted;
- the count is frozen while disabled;
- the strobe is single-cycle and tied to the mid-bit count;
- no bit window carries more than one correction.

Other behaviour shows only through the bench's scenarios. Whether the loop actually locks at a ±3% rate offset, whether glitches stay out of the recovered data, and whether a long run keeps the strobe period exact are checked there. Those scenarios use a behavioural model that follows the bit-level outputs clock by clock.

// File: rtl/cdr_dpll.sv
module cdr_dpll #(
  parameter int OSR       = 32,
  parameter int HOLD_BAND = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic bclk,
  output logic dout,
  output logic dvalid
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2);
  localparam logic [CW-1:0] LOWB = CW'(HOLD_BAND);
  localparam logic [CW-1:0] HIGB = CW'(OSR - HOLD_BAND);

  logic          s0, s1, lvl, done;
  logic [CW-1:0] cnt, cnt_nx;
  logic          ev, in_hold, lengthen, shorten, at_mid;

  // accepted transition: two agreeing samples that differ from the held level
  assign ev       = (s0 == s1) && (s1 != lvl);
  assign in_hold  = (cnt <= LOWB) || (cnt >= HIGB);
  assign lengthen = en && ev && !done && !in_hold && (cnt <  MID);
  assign shorten  = en && ev && !done && !in_hold && (cnt >= MID);
  assign at_mid   = en && (cnt == MID);
  assign bclk     = cnt[CW-1];

  always_comb begin
    if (lengthen)     cnt_nx = cnt;
    else if (shorten) cnt_nx = cnt + CW'(2);
    else              cnt_nx = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0     <= 1'b0;
      s1     <= 1'b0;
      lvl    <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      dout   <= 1'b0;
      dvalid <= 1'b0;
    end else begin
      s0     <= din;
      s1     <= s0;
      if (ev) lvl <= s1;
      dvalid <= at_mid;
      if (at_mid) dout <= lvl;
      if (en) begin
        cnt <= cnt_nx;
        if (cnt_nx == '0)             done <= 1'b0;
        else if (lengthen || shorten) done <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [CW-1:0] cnt_q;
  logic          en_q;
  logic [1:0]    irr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      irr   <= '0;
    end else begin
      cnt_q <= cnt;
      en_q  <= en;
      if (cnt < cnt_q)                                irr <= '0;
      else if (en_q && cnt != cnt_q + CW'(1) && irr != 2'd3) irr <= irr + 2'd1;
    end
  end

  p_one_corr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irr <= 2'd1);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (CW'(cnt - $past(cnt)) <= CW'(2)));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ev) |=> (cnt == CW'($past(cnt) + CW'(1))));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == $past(cnt)));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |=> !dvalid);

  p_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> ($past(cnt) == MID && $past(en)));

  p_glitch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s0 != s1) |=> $stable(lvl));
endmodule

// File: tb/tb_cdr_dpll.sv
module tb_cdr_dpll;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, din = 1'b0;
  logic bclk, dout, dvalid;

  always #(PERIOD / 2) clk = ~clk;

  cdr_dpll dut (.clk(clk), .rst_n(rst_n), .en(en), .din(din),
                .bclk(bclk), .dout(dout), .dvalid(dvalid));

  int compared = 0, mismatched = 0;
  // behavioural reference state
  int m_cnt = 0;
  bit m_s0, m_s1, m_lvl, m_done, m_dout, m_dv;
  // stimulus source
  int acc = 0;
  bit cur_bit = 0;
  logic [6:0] lfsr = 7'h5A;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step_model();
    bit ev, nv;
    int corr, nx;
    if (!rst_n) begin
      m_cnt = 0; m_s0 = 0; m_s1 = 0; m_lvl = 0; m_done = 0; m_dout = 0; m_dv = 0;
    end else begin
      ev = (m_s0 == m_s1) && (m_s1 != m_lvl);
      corr = 0;
      if (en && ev && !m_done && m_cnt >= 2 && m_cnt <= 30) corr = (m_cnt < 16) ? -1 : 1;
      nx = (m_cnt + 1 + corr) % 32;
      nv = en && (m_cnt == 16);
      if (nv) m_dout = m_lvl;
      m_dv = nv;
      if (en) begin
        if (nx == 0) m_done = 0;
        else if (corr != 0) m_done = 1;
        m_cnt = nx;
      end
      if (ev) m_lvl = m_s1;
      m_s1 = m_s0;
      m_s0 = din;
    end
  endtask

  function automatic bit next_bit(input int mode);
    if (mode == 0) return ~cur_bit;
    if (mode == 1) begin
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      return lfsr[0];
    end
    return cur_bit;
  endfunction

  // mode: 0 alternating, 1 pseudo-random, 2 constant, 3 single-sample glitches on 0
  task automatic run(input int n, input int mode, input int per, input bit e,
                     input string tag, input bit r9, input bit r6, input bit r8, input bit r3);
    int ns = 0, gap = 0;
    bit last = 0, bclk0 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check({bclk, dout, dvalid} === {bit'(m_cnt >= 16), m_dout, m_dv}, tag,
            int'({bclk, dout, dvalid}), int'({bit'(m_cnt >= 16), m_dout, m_dv}));
      if (r9 && dvalid) begin
        ns++;
        if (ns > 64) check(dout != last, "R9 alternation after lock", dout, !last);
        last = dout;
      end
      if (r6) begin
        if (dvalid) begin
          if (ns >= 2) check(gap == 32, "R6 strobe spacing in run", gap, 32);
          gap = 0;
          ns++;
        end
        gap++;
      end
      if (r8) begin
        if (i == 2) bclk0 = bclk;
        if (i > 2) check(!dvalid && bclk == bclk0, "R8 frozen while disabled",
                         int'({bclk, dvalid}), int'({bclk0, 1'b0}));
      end
      if (r3 && dvalid) check(dout == 1'b0, "R3 glitch leaked to data", dout, 0);
      acc += 1000;
      if (acc >= per) begin
        acc -= per;
        cur_bit = next_bit(mode);
      end
      din = (mode == 3) ? (i % 45 == 20) : cur_bit;
      en  = e;
      step_model();
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    run(4, 2, 32000, 1'b0, "R1 reset", 0, 0, 0, 0);
    check({bclk, dout, dvalid} == 3'b000, "R1 reset outputs", int'({bclk, dout, dvalid}), 0);
    rst_n = 1'b1;
    cur_bit = 0;
    run(200, 2, 32000, 1'b1, "R2 R6 free run", 0, 1, 0, 0);
    acc = 400;
    run(4300, 0, 31068, 1'b1, "R4 R9 fast alternating", 1, 0, 0, 0);
    acc = 0;
    run(4300, 0, 32990, 1'b1, "R4 R9 slow alternating", 1, 0, 0, 0);
    acc = 700;
    run(3200, 1, 32000, 1'b1, "R4 R5 R7 random data", 0, 0, 0, 0);
    run(400, 0, 16000, 1'b1, "R5 double rate edges", 0, 0, 0, 0);
    cur_bit = 1;
    run(1400, 2, 32000, 1'b1, "R6 long run of ones", 0, 1, 0, 0);
    cur_bit = 0;
    run(100, 2, 32000, 1'b1, "R3 settle low", 0, 0, 0, 0);
    run(900, 3, 32000, 1'b1, "R3 glitch filter", 0, 0, 0, 1);
    run(300, 0, 32000, 1'b0, "R8 disabled", 0, 0, 1, 0);
    run(400, 0, 32000, 1'b1, "R8 resume R7", 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule